// File: doc/BRIEF.md
# Clock Group Source Selector and Ratio Divider

This block produces one derived clock for a member of a clock group. Up to eight source clocks arrive at its input. A 3-bit switch field and a 6-bit selection field decide which source is used and how far it is divided. Several members of a group share the same switch and selection register regions. Each member owns a field that starts at its own bit offset in those regions. Software loads the fields through a plain word-write port. The port carries a region flag, a word index and 32 data bits. A member takes its bits only from the word at index offset/32, starting at bit offset%32.

The switch field has three controls. Bit 0 enables source selection. Bit 1 enables the table divider. Bit 2 forces a fixed divide by three and wins over bit 1. The selection field has two parts. Bits 2:0 hold the source index and bits 5:3 hold a divider code. The block runs on a fast system clock. It resynchronises every source and counts both edges of the chosen one. The output toggles once every `ratio` source edges, which gives a 50% duty cycle for every ratio, three included. New settings are held as pending. They become active only when the output is low and no count is in progress, so a change never shortens a pulse. A 4-bit output reports the ratio that is active at that moment.

All pins are plain control and clock pins. There is no streaming data path, so no pin has valid/ready handshaking or back-pressure. The source clocks must hold each level for at least two system-clock cycles.

Top module: `clkgrp_sel_div`

## Requirements
- R1: While reset is asserted and right after it is released, clk_o is low and rate_o is 1. Both fields are zero, so source 0 is used with no division.
- R2: A write with wr_region_i=0 loads the switch field from wr_data_i[SW_OFFSET%32 +: 3], only when wr_addr_i equals SW_OFFSET/32. A write with wr_region_i=1 loads the selection field from wr_data_i[SEL_OFFSET%32 +: 6], only when wr_addr_i equals SEL_OFFSET/32. A write to any other word or region leaves both fields unchanged, and all other data bits are ignored.
- R3: When switch bit 0 is 1, the source index is selection bits 2:0. When switch bit 0 is 0, source 0 is used and selection bits 2:0 have no effect.
- R4: When switch bit 2 is 1, the ratio is 3 whatever bit 1 holds. When bit 2 is 0 and bit 1 is 1, the ratio comes from the table of R5. When both are 0, the ratio is 1.
- R5: Divider codes (selection bits 5:3) 0, 1, 2, 3, 4, 5, 6 and 7 give ratios 1, 2, 4, 6, 8, 12, 1 and 1. rate_o never shows a value outside {1,2,3,4,6,8,12}.
- R6: Once settings are in effect, each high phase and each low phase of clk_o lasts exactly `ratio` half-periods of the selected source.
- R7: New settings become active only while clk_o is low and no source edge has been counted since it fell. A high phase that is already running finishes with its old length. clk_o changes only in the cycle after an edge of the selected source has been seen.
- R8: rate_o shows the active ratio. It keeps the old value until the new settings take effect at the point given in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than every source |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_clk_i | input | NUM_SRC | Source clocks, one per index |
| wr_en_i | input | 1 | Word write strobe |
| wr_region_i | input | 1 | 0 = switch region, 1 = selection region |
| wr_addr_i | input | ADDR_W | 32-bit word index within the region |
| wr_data_i | input | 32 | Write data word |
| clk_o | output | 1 | Derived output clock |
| rate_o | output | 4 | Ratio currently in effect |

## Verification
The bench runs every divider code and checks priority. It sets switch bits 1 and 2 together, and in that case a divider that ignored the priority would show the table ratio instead of 3. It also checks that source selection is masked. It writes a non-zero index while bit 0 is clear, and a design that did not mask the index would output the wrong source's period. Field extraction is tested with noise in the other data bits and with writes to the wrong word or region. Any of these would corrupt the rate if the decode were wrong. Finally, the bench changes the settings in the middle of a long high phase and checks that this phase keeps its old length and that the rate does not move early. A design that applied settings at once would produce a runt pulse here.

// File: rtl/clkgrp_pkg.sv
package clkgrp_pkg;
  localparam int SW_W    = 3;
  localparam int SEL_W   = 6;
  localparam int RATE_W  = 4;
  localparam int IDX_W   = 3;
  localparam int MAX_SRC = 1 << IDX_W;

  typedef struct packed {
    logic [IDX_W-1:0]  src;
    logic [RATE_W-1:0] ratio;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{src: '0, ratio: RATE_W'(1)};

  function automatic logic [RATE_W-1:0] code_ratio(input logic [2:0] code);
    case (code)
      3'd0:    code_ratio = RATE_W'(1);
      3'd1:    code_ratio = RATE_W'(2);
      3'd2:    code_ratio = RATE_W'(4);
      3'd3:    code_ratio = RATE_W'(6);
      3'd4:    code_ratio = RATE_W'(8);
      3'd5:    code_ratio = RATE_W'(12);
      default: code_ratio = RATE_W'(1);
    endcase
  endfunction

  function automatic cfg_t decode_cfg(input logic [SW_W-1:0] sw,
                                      input logic [SEL_W-1:0] sel);
    cfg_t c;
    c.src = sw[0] ? sel[IDX_W-1:0] : '0;
    if (sw[2])      c.ratio = RATE_W'(3);
    else if (sw[1]) c.ratio = code_ratio(sel[5:3]);
    else            c.ratio = RATE_W'(1);
    return c;
  endfunction
endpackage

// File: rtl/clkgrp_field_port.sv
module clkgrp_field_port #(
  parameter int OFFSET = 0,
  parameter int W      = 3,
  parameter bit REGION = 1'b0,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              wr_region_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  output logic [W-1:0]      field_o
);
  localparam int WORD = OFFSET / 32;
  localparam int POS  = OFFSET % 32;

  logic hit;
  assign hit = wr_en_i && (wr_region_i == REGION) && (wr_addr_i == ADDR_W'(WORD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   field_o <= '0;
    else if (hit) field_o <= wr_data_i[POS +: W];
  end

  AST_FIELD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> field_o == $past(wr_data_i[POS +: W])); // R2
  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(field_o)); // R2
endmodule

// File: rtl/clkgrp_src_edges.sv
module clkgrp_src_edges #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_SRC-1:0] edge_o
);
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        s3 <= 1'b0;
      end else begin
        s1 <= src_i[k];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign edge_o[k] = s2 ^ s3;
  end
endmodule

// File: rtl/clkgrp_edge_div.sv
module clkgrp_edge_div
  import clkgrp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic edge_i,
  input  cfg_t pend_i,
  output cfg_t act_o,
  output logic out_o
);
  logic [RATE_W-1:0] cnt;
  logic              safe;
  logic              last;

  assign safe = !out_o && (cnt == '0) && !edge_i;
  assign last = (cnt == act_o.ratio - RATE_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_o <= CFG_RESET;
      cnt   <= '0;
      out_o <= 1'b0;
    end else begin
      if (safe) act_o <= pend_i;
      if (edge_i) begin
        if (last) begin
          cnt   <= '0;
          out_o <= ~out_o;
        end else begin
          cnt <= cnt + RATE_W'(1);
        end
      end
    end
  end

  AST_SAFE_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (act_o != $past(act_o)) |-> (!out_o && $past(!out_o))); // R7
  AST_OUT_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_o) |-> $past(edge_i)); // R7
  AST_CNT_BELOW_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < act_o.ratio); // R6
endmodule

// File: rtl/clkgrp_sel_div.sv
module clkgrp_sel_div
  import clkgrp_pkg::*;
#(
  parameter int NUM_SRC    = 8,
  parameter int ADDR_W     = 4,
  parameter int SW_OFFSET  = 37,
  parameter int SEL_OFFSET = 70
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_clk_i,
  input  logic               wr_en_i,
  input  logic               wr_region_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [31:0]        wr_data_i,
  output logic               clk_o,
  output logic [3:0]         rate_o
);
  logic [SW_W-1:0]    sw_f;
  logic [SEL_W-1:0]   sel_f;
  logic [NUM_SRC-1:0] edges;
  logic [MAX_SRC-1:0] edge_pad;
  logic               edge_sel;
  cfg_t               pend, act;

  clkgrp_field_port #(.OFFSET(SW_OFFSET), .W(SW_W), .REGION(1'b0), .ADDR_W(ADDR_W)) u_sw (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_region_i(wr_region_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .field_o(sw_f));

  clkgrp_field_port #(.OFFSET(SEL_OFFSET), .W(SEL_W), .REGION(1'b1), .ADDR_W(ADDR_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_region_i(wr_region_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .field_o(sel_f));

  clkgrp_src_edges #(.NUM_SRC(NUM_SRC)) u_edges (
    .clk(clk), .rst_n(rst_n), .src_i(src_clk_i), .edge_o(edges));

  assign pend = decode_cfg(sw_f, sel_f);

  always_comb begin
    edge_pad = '0;
    edge_pad[NUM_SRC-1:0] = edges;
  end
  assign edge_sel = edge_pad[act.src];

  clkgrp_edge_div u_div (
    .clk(clk), .rst_n(rst_n), .edge_i(edge_sel), .pend_i(pend),
    .act_o(act), .out_o(clk_o));

  assign rate_o = act.ratio;

  AST_RATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rate_o inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd6, 4'd8, 4'd12}); // R5
  AST_RATE_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clk_o) |-> $stable(rate_o)); // R8
endmodule

// File: tb/clkgrp_sel_div_tb.sv
module clkgrp_sel_div_tb;
  localparam int SW_OFF  = 37;
  localparam int SEL_OFF = 70;
  localparam int SW_WORD = SW_OFF / 32;
  localparam int SW_POS  = SW_OFF % 32;
  localparam int SEL_WORD = SEL_OFF / 32;
  localparam int SEL_POS  = SEL_OFF % 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src = '0;
  logic       wr_en = 1'b0;
  logic       wr_region = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic       clk_o;
  logic [3:0] rate_o;

  int checks = 0;
  int failures = 0;
  int exp_q[$];
  string tag_q[$];
  int cur_half;

  always #5 clk = ~clk;

  clkgrp_sel_div #(.NUM_SRC(8), .ADDR_W(4), .SW_OFFSET(SW_OFF), .SEL_OFFSET(SEL_OFF)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_clk_i(src), .wr_en_i(wr_en), .wr_region_i(wr_region),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .clk_o(clk_o), .rate_o(rate_o));

  // source k holds each level for k+2 system cycles
  initial begin
    int cnt [8];
    for (int k = 0; k < 8; k++) cnt[k] = 0;
    forever begin
      @(posedge clk);
      for (int k = 0; k < 8; k++) begin
        if (cnt[k] == k + 1) begin
          cnt[k] = 0;
          src[k] <= ~src[k];
        end else begin
          cnt[k] = cnt[k] + 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input bit region, input int addr, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_region = region; wr_addr = 4'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  function automatic logic [31:0] pack(input int pos, input int w, input int val);
    logic [31:0] m;
    m = ((32'd1 << w) - 32'd1) << pos;
    return (32'hA5C3_5A3C & ~m) | ((32'(val) << pos) & m);
  endfunction

  task automatic write_cfg(input int sw, input int sel);
    wr(1'b0, SW_WORD, pack(SW_POS, 3, sw));
    wr(1'b1, SEL_WORD, pack(SEL_POS, 6, sel));
  endtask

  task automatic expect_periods(input int half, input string tag);
    exp_q.push_back(half); tag_q.push_back(tag);
    exp_q.push_back(half); tag_q.push_back(tag);
    wait (exp_q.size() == 0);
    cur_half = half;
  endtask

  task automatic run_cfg(input int sw, input int sel, input int rate, input int half,
                         input string tag);
    write_cfg(sw, sel);
    repeat (3) @(negedge clk_o);
    @(negedge clk);
    check(rate_o == 4'(rate), {tag, " rate"}, rate_o, rate);
    expect_periods(half, tag);
  endtask

  // monitor: measures one high and one low phase per queued item
  initial begin
    int hi, lo, e;
    string t;
    forever begin
      wait (exp_q.size() > 0);
      @(posedge clk_o);
      hi = 0;
      @(negedge clk);
      while (clk_o) begin hi++; @(negedge clk); end
      lo = 0;
      while (!clk_o) begin lo++; @(negedge clk); end
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(hi == e, {t, " high"}, hi, e);
      check(lo == e, {t, " low"}, lo, e);
    end
  end

  initial begin
    #1_500_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int hi;
    repeat (4) @(negedge clk);
    check(clk_o == 1'b0, "R1 out in reset", clk_o, 0);
    check(rate_o == 4'd1, "R1 rate in reset", rate_o, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(rate_o == 4'd1, "R1 rate after reset", rate_o, 1);
    expect_periods(2, "R1 R6 default src0 ratio1");

    run_cfg(3'b011, (1 << 3) | 3, 2, 10, "R3 R5 code1 src3");
    run_cfg(3'b001, (5 << 3) | 2, 1, 4, "R4 both clear src2");
    run_cfg(3'b111, (5 << 3) | 1, 3, 9, "R4 div3 priority src1");
    run_cfg(3'b010, (5 << 3) | 5, 12, 24, "R3 R5 select off code5");
    run_cfg(3'b011, (0 << 3) | 7, 1, 9, "R5 code0");
    run_cfg(3'b011, (2 << 3) | 7, 4, 36, "R5 code2");
    run_cfg(3'b011, (3 << 3) | 7, 6, 54, "R5 code3");
    run_cfg(3'b011, (6 << 3) | 7, 1, 9, "R5 code6");
    run_cfg(3'b011, (7 << 3) | 7, 1, 9, "R5 code7");
    run_cfg(3'b011, (4 << 3) | 7, 8, 72, "R5 code4");

    // R2: writes to other words or the other region change nothing
    wr(1'b0, SW_WORD + 1, pack(SW_POS, 3, 3'b000));
    wr(1'b1, SW_WORD, pack(SEL_POS, 6, 6'h00));
    wr(1'b0, SEL_WORD, pack(SW_POS, 3, 3'b000));
    wr(1'b1, SEL_WORD + 1, pack(SEL_POS, 6, 6'h00));
    repeat (3) @(negedge clk_o);
    @(negedge clk);
    check(rate_o == 4'd8, "R2 foreign writes rate", rate_o, 8);
    expect_periods(72, "R2 foreign writes period");

    // R7 R8: change settings mid high phase
    hi = 0;
    fork
      begin
        @(posedge clk_o);
        @(negedge clk);
        while (clk_o) begin hi++; @(negedge clk); end
      end
      begin
        @(posedge clk_o);
        repeat (2) @(negedge clk);
        write_cfg(3'b000, 6'h3F);
        @(negedge clk);
        check(clk_o == 1'b1, "R7 still high after write", clk_o, 1);
        check(rate_o == 4'd8, "R8 rate held while high", rate_o, 8);
      end
    join
    check(hi == 72, "R7 high phase keeps old length", hi, 72);
    repeat (3) @(negedge clk_o);
    @(negedge clk);
    check(rate_o == 4'd1, "R8 rate after safe point", rate_o, 1);
    expect_periods(2, "R3 R7 new settings src0");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule